// File: doc/BRIEF.md
# Redundant Equality Guard

This block decides whether two operands are equal. It is meant for checks whose result gates something sensitive, such as a token match that must succeed before a key is derived or before a state change is allowed. A single glitched gate or a perturbed flop must not turn a mismatch into a match. The equality is therefore computed four times. Two separate lanes see the operands as captured on the start edge: one compares them directly, the other compares their bitwise complements through a different logic form. The operands are then sampled again one clock later, and the same pair of lanes compares that second sample.

Each lane reports its result as a 4-bit code word. The two legal words are far apart in Hamming distance. A voter accepts the result only when all four words are identical and legal, and when the operands did not move between the two samples. Any other outcome raises a one-cycle alert and sets a sticky fault flag. While that flag is set, the block never reports a pass. The result appears three clock edges after start is accepted. At every other time the result port carries the fail word.

Top module: `seccmp_top`

## Requirements
- R1: After a synchronous reset (rst_n low on a rising edge), verdict_o is the fail word 4'b0101, and done_o, alert_o and fault_o are 0.
- R2: When start_i is high on a rising edge while no comparison is in flight, done_o is high for exactly one cycle, starting at the third rising edge after the accepting edge.
- R3: verdict_o carries the pass word 4'b1010 only in the done cycle, and only when the operands captured at the accepting edge are equal, all checks agree and fault_o was clear. In every other cycle it carries 4'b0101.
- R4: The comparison is carried out by a direct lane and a separate lane working on inverted operands, for each of the two samples. If any single lane disagrees with the others, the done cycle shows alert_o high and verdict_o at 4'b0101.
- R5: The operands are sampled again on the rising edge after the accepting edge. If either operand differs from its first sample, the done cycle raises alert_o and shows 4'b0101, even when the two new operands are equal to each other.
- R6: A lane code word that is neither 4'b1010 nor 4'b0101 is treated as a fault: alert_o is raised and verdict_o stays 4'b0101.
- R7: alert_o is a single-cycle pulse that coincides with done_o.
- R8: fault_o is set on the same edge that raises alert_o, and it stays set until the next reset.
- R9: While fault_o is set, verdict_o never shows 4'b1010, even for equal and stable operands.
- R10: start_i is ignored while a comparison is in flight, including on the edge that raises done_o. Holding start_i high therefore starts a new comparison every fourth edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Request a comparison; sampled only when idle |
| opa_i | input | WIDTH | First operand, must be held for two edges from start |
| opb_i | input | WIDTH | Second operand, must be held for two edges from start |
| verdict_o | output | 4 | Encoded result: 4'b1010 pass, 4'b0101 fail |
| done_o | output | 1 | One-cycle strobe marking a valid verdict |
| alert_o | output | 1 | One-cycle pulse on a detected disagreement |
| fault_o | output | 1 | Sticky fault flag, cleared only by reset |

## Verification
The bench forces each of the four lane registers in turn, for one comparison, to a wrong legal word or to an illegal word. A voter that ignored a lane, or that checked only legality, would release a pass or stay silent instead of raising the alert. Operands that change between the two samples cover the temporal check, including the case where both change to the same new value; a design that compared only the second sample would report a pass there. Further runs check that pass stays suppressed after a fault, and that a start held high is ignored while busy, so that back-to-back requests neither shorten nor stack comparisons.

// File: rtl/seccmp_pkg.sv
// Shared definitions for the redundant equality guard.
// Assumes a 4-bit code word; the two legal words differ in every bit.
package seccmp_pkg;
    localparam int CODE_W  = 4;
    localparam int N_LANES = 4;

    typedef logic [CODE_W-1:0] code_t;

    localparam code_t CODE_PASS = 4'b1010;
    localparam code_t CODE_FAIL = 4'b0101;

    // True when the word is one of the two legal encodings.
    function automatic logic code_legal(code_t c);
        return (c == CODE_PASS) || (c == CODE_FAIL);
    endfunction
endpackage

// File: rtl/seccmp_lane.sv
// One comparison lane: turns operand equality into a code word.
// INVERT selects the complement lane, which works on ~a and ~b through an
// XOR reduction, so its logic shares no structure with the direct lane.
// Assumes the operands are stable for the cycle in which the code is used.
module seccmp_lane
    import seccmp_pkg::*;
#(
    parameter int WIDTH  = 32,
    parameter bit INVERT = 1'b0
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    output code_t            code_o
);
    logic match;

    generate
        if (INVERT) begin : g_inv
            logic [WIDTH-1:0] na, nb, diff;
            // Complement both operands and look for any differing bit.
            assign na    = ~a_i;
            assign nb    = ~b_i;
            assign diff  = na ^ nb;
            assign match = ~|diff;
        end else begin : g_direct
            // Straight magnitude-free equality on the true operands.
            assign match = (a_i == b_i);
        end
    endgenerate

    // Expand the single result into a wide-distance word.
    assign code_o = match ? CODE_PASS : CODE_FAIL;
endmodule

// File: rtl/seccmp_vote.sv
// Voter: combines the lane words and the operand-drift flag.
// agree_o is high only when every lane word is legal, all are identical and
// no drift was seen; pass_o then tells whether the common word is a pass.
module seccmp_vote
    import seccmp_pkg::*;
(
    input  code_t lane_i [N_LANES],
    input  logic  drift_i,
    output logic  agree_o,
    output logic  pass_o
);
    // Walk every lane against the first and check legality of each.
    always_comb begin
        agree_o = ~drift_i;
        for (int i = 0; i < N_LANES; i++) begin
            if (!code_legal(lane_i[i]) || (lane_i[i] != lane_i[0])) begin
                agree_o = 1'b0;
            end
        end
        pass_o = agree_o && (lane_i[0] == CODE_PASS);
    end
endmodule

// File: rtl/seccmp_top.sv
// Redundant equality guard: spatially and temporally repeated comparison.
// Edge E0 accepts start and captures the operands; E1 captures them again
// and registers the first-sample lanes and the drift flag; E2 registers the
// second-sample lanes; E3 votes and drives done/verdict/alert/fault.
// Assumes the caller holds the operands steady from E0 through E1.
module seccmp_top
    import seccmp_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [WIDTH-1:0] opa_i,
    input  logic [WIDTH-1:0] opb_i,
    output logic [3:0]       verdict_o,
    output logic             done_o,
    output logic             alert_o,
    output logic             fault_o
);
    logic             stg1_q, stg2_q, stg3_q;
    logic             busy, accept;
    logic [WIDTH-1:0] s0_a_q, s0_b_q, s1_a_q, s1_b_q;
    logic             drift_q;
    code_t            pri0_c, red0_c, pri1_c, red1_c;
    code_t            pri0_q, red0_q, pri1_q, red1_q;
    code_t            lanes [N_LANES];
    logic             agree, pass;
    code_t            verdict_q;
    logic             done_q, alert_q, fault_q;

    assign busy   = stg1_q | stg2_q | stg3_q;
    assign accept = start_i & ~busy;

    // Three-stage valid pipeline tracking one comparison in flight.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg1_q <= 1'b0;
            stg2_q <= 1'b0;
            stg3_q <= 1'b0;
        end else begin
            stg1_q <= accept;
            stg2_q <= stg1_q;
            stg3_q <= stg2_q;
        end
    end

    // Capture the first and second operand samples and detect drift.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s0_a_q  <= '0;
            s0_b_q  <= '0;
            s1_a_q  <= '0;
            s1_b_q  <= '0;
            drift_q <= 1'b0;
        end else begin
            if (accept) begin
                s0_a_q <= opa_i;
                s0_b_q <= opb_i;
            end
            if (stg1_q) begin
                s1_a_q  <= opa_i;
                s1_b_q  <= opb_i;
                drift_q <= (opa_i != s0_a_q) || (opb_i != s0_b_q);
            end
        end
    end

    // Four lanes: direct and complement, on each of the two samples.
    seccmp_lane #(.WIDTH(WIDTH), .INVERT(1'b0)) u_pri0 (.a_i(s0_a_q), .b_i(s0_b_q), .code_o(pri0_c));
    seccmp_lane #(.WIDTH(WIDTH), .INVERT(1'b1)) u_red0 (.a_i(s0_a_q), .b_i(s0_b_q), .code_o(red0_c));
    seccmp_lane #(.WIDTH(WIDTH), .INVERT(1'b0)) u_pri1 (.a_i(s1_a_q), .b_i(s1_b_q), .code_o(pri1_c));
    seccmp_lane #(.WIDTH(WIDTH), .INVERT(1'b1)) u_red1 (.a_i(s1_a_q), .b_i(s1_b_q), .code_o(red1_c));

    // Register every lane word separately so no lane shares a flop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pri0_q <= CODE_FAIL;
            red0_q <= CODE_FAIL;
            pri1_q <= CODE_FAIL;
            red1_q <= CODE_FAIL;
        end else begin
            pri0_q <= pri0_c;
            red0_q <= red0_c;
            pri1_q <= pri1_c;
            red1_q <= red1_c;
        end
    end

    assign lanes[0] = pri0_q;
    assign lanes[1] = red0_q;
    assign lanes[2] = pri1_q;
    assign lanes[3] = red1_q;

    seccmp_vote u_vote (
        .lane_i  (lanes),
        .drift_i (drift_q),
        .agree_o (agree),
        .pass_o  (pass)
    );

    // Release the verdict in the done cycle and latch any fault.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            verdict_q <= CODE_FAIL;
            done_q    <= 1'b0;
            alert_q   <= 1'b0;
            fault_q   <= 1'b0;
        end else begin
            done_q    <= stg3_q;
            alert_q   <= stg3_q & ~agree;
            fault_q   <= fault_q | (stg3_q & ~agree);
            verdict_q <= (stg3_q && pass && !fault_q) ? CODE_PASS : CODE_FAIL;
        end
    end

    assign verdict_o = verdict_q;
    assign done_o    = done_q;
    assign alert_o   = alert_q;
    assign fault_o   = fault_q;
endmodule

// File: rtl/seccmp_chk.sv
// Port-level checker for the redundant equality guard, bound to the top.
// Assumes the bench holds rst_n low from time zero.
module seccmp_chk
    import seccmp_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       start_i,
    input logic [3:0] verdict_o,
    input logic       done_o,
    input logic       alert_o,
    input logic       fault_o
);
    // R3
    verdict_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (verdict_o == CODE_PASS) || (verdict_o == CODE_FAIL));

    // R3
    pass_in_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (verdict_o == CODE_PASS) |-> done_o);

    // R2
    done_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(start_i, 4));

    // R2
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R7
    alert_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alert_o |-> (done_o && verdict_o == CODE_FAIL));

    // R8
    fault_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |=> fault_o);

    // R8
    fault_rise_alert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault_o) |-> alert_o);

    // R9
    no_pass_faulted_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |-> (verdict_o != CODE_PASS));
endmodule

bind seccmp_top seccmp_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .verdict_o (verdict_o),
    .done_o    (done_o),
    .alert_o   (alert_o),
    .fault_o   (fault_o)
);

// File: tb/tb_seccmp_top.sv
// Bench for seccmp_top: a behavioural model, updated on each rising edge,
// is compared against every output on each falling edge.
module tb_seccmp_top;
    localparam int W = 32;
    localparam logic [3:0] PASS_W = 4'b1010;
    localparam logic [3:0] FAIL_W = 4'b0101;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [W-1:0] opa = '0, opb = '0;
    logic [3:0]   verdict;
    logic         done, alert, fault;

    int    n_chk = 0, n_fail = 0;
    int    done_cnt = 0, alert_cnt = 0;
    bit    chk_en = 1'b0;
    bit    inj = 1'b0;
    string cur = "R3";

    // model state
    int           m_cnt = 0;
    logic [W-1:0] m_a0, m_b0, m_a1, m_b1;
    bit           m_inj = 1'b0;
    logic [3:0]   e_v = FAIL_W;
    bit           e_d = 1'b0, e_al = 1'b0, e_f = 1'b0;

    always #2 clk = ~clk;

    seccmp_top #(.WIDTH(W)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .opa_i(opa), .opb_i(opb),
        .verdict_o(verdict), .done_o(done), .alert_o(alert), .fault_o(fault)
    );

    task automatic check(input string req, input string what,
                         input logic [3:0] act, input logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
        end
    endtask

    // Reference model: one comparison in flight, result three edges later.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; e_v = FAIL_W; e_d = 0; e_al = 0; e_f = 0;
        end else begin
            e_d = 0; e_al = 0; e_v = FAIL_W;
            if (m_cnt == 3) begin
                e_d = 1;
                if (m_inj || m_a0 != m_a1 || m_b0 != m_b1) begin
                    e_al = 1; e_f = 1;
                end else if (!e_f && m_a0 == m_b0) begin
                    e_v = PASS_W;
                end
                m_cnt = 0;
            end else if (m_cnt == 2) begin
                m_cnt = 3;
            end else if (m_cnt == 1) begin
                m_a1 = opa; m_b1 = opb; m_cnt = 2;
            end else if (start) begin
                m_a0 = opa; m_b0 = opb; m_inj = inj; m_cnt = 1;
            end
        end
    end

    // Per-cycle comparison of all outputs against the model.
    always @(negedge clk) begin
        if (chk_en) begin
            check("R2", "done", {3'b0, done}, {3'b0, e_d});
            check(cur, "verdict", verdict, e_v);
            check(cur, "alert", {3'b0, alert}, {3'b0, e_al});
            check("R8", "fault", {3'b0, fault}, {3'b0, e_f});
            if (done) done_cnt++;
            if (alert) alert_cnt++;
        end
    end

    // Drive one comparison; kind selects a lane to corrupt (0 = none).
    task automatic txn(input logic [W-1:0] a, b, a2, b2, input int kind, input string tag);
        cur = tag;
        @(negedge clk);
        case (kind)
            1: force dut.pri0_q = FAIL_W;
            2: force dut.red0_q = PASS_W;
            3: force dut.pri1_q = FAIL_W;
            4: force dut.red1_q = 4'hF;
            default: ;
        endcase
        inj = (kind != 0);
        start = 1'b1; opa = a; opb = b;
        @(negedge clk);
        start = 1'b0; opa = a2; opb = b2;
        repeat (4) @(negedge clk);
        case (kind)
            1: release dut.pri0_q;
            2: release dut.red0_q;
            3: release dut.pri1_q;
            4: release dut.red1_q;
            default: ;
        endcase
        inj = 1'b0;
        @(negedge clk);
        cur = "R3";
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk);
        check("R1", "fault after reset", {3'b0, fault}, 4'h0);
        check("R1", "verdict after reset", verdict, FAIL_W);
        rst_n = 1'b1;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        int d0;
        repeat (3) @(negedge clk);
        check("R1", "verdict in reset", verdict, FAIL_W);
        check("R1", "done in reset", {3'b0, done}, 4'h0);
        check("R1", "alert in reset", {3'b0, alert}, 4'h0);
        check("R1", "fault in reset", {3'b0, fault}, 4'h0);
        rst_n = 1'b1;
        chk_en = 1'b1;

        // R3: clean equal and unequal patterns
        txn(32'hDEADBEEF, 32'hDEADBEEF, 32'hDEADBEEF, 32'hDEADBEEF, 0, "R3");
        txn(32'hDEADBEEF, 32'hDEADBEEE, 32'hDEADBEEF, 32'hDEADBEEE, 0, "R3");
        txn(32'h0, 32'h0, 32'h0, 32'h0, 0, "R3");
        txn(32'hFFFFFFFF, 32'h7FFFFFFF, 32'hFFFFFFFF, 32'h7FFFFFFF, 0, "R3");
        txn(32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 0, "R3");

        // R10: start held high, only every fourth edge accepted
        cur = "R10";
        d0 = done_cnt;
        @(negedge clk);
        opa = 32'h1234; opb = 32'h1234; start = 1'b1;
        repeat (8) @(negedge clk);
        start = 1'b0;
        repeat (5) @(negedge clk);
        check("R10", "done pulses for held start", 4'(done_cnt - d0), 4'd2);
        cur = "R3";

        // R5: drift where both operands move to the same new value
        d0 = alert_cnt;
        txn(32'hA5A5A5A5, 32'hA5A5A5A5, 32'h5A5A5A5A, 32'h5A5A5A5A, 0, "R5");
        check("R7", "alert pulse count", 4'(alert_cnt - d0), 4'd1);
        check("R8", "fault held", {3'b0, fault}, 4'h1);

        // R9: a clean equal compare after a fault must not pass
        txn(32'h77, 32'h77, 32'h77, 32'h77, 0, "R9");
        check("R8", "fault still held", {3'b0, fault}, 4'h1);
        do_reset();

        // R5: drift on a single operand
        txn(32'h10, 32'h10, 32'h10, 32'h11, 0, "R5");
        do_reset();

        // R4: each lane corrupted in turn
        txn(32'hC0FFEE, 32'hC0FFEE, 32'hC0FFEE, 32'hC0FFEE, 1, "R4");
        do_reset();
        txn(32'h1, 32'h2, 32'h1, 32'h2, 2, "R4");
        do_reset();
        txn(32'h99, 32'h99, 32'h99, 32'h99, 3, "R4");
        do_reset();

        // R6: illegal code word on one lane
        txn(32'h42, 32'h42, 32'h42, 32'h42, 4, "R6");
        do_reset();

        // recovery after reset: a clean pass again
        txn(32'hBEEF, 32'hBEEF, 32'hBEEF, 32'hBEEF, 0, "R3");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule